// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Port

This block sits between an interrupt distributor and one processor. Each cycle the distributor offers its best pending candidate: a valid flag, a 10-bit interrupt number, a 3-bit requester field and an 8-bit priority. The port decides whether that candidate may interrupt the processor. If it may, the port drives a level request line to the processor.

Software on the processor reaches the port through a small 32-bit register bus. The bus has four word slots:

- a control word, whose bit 0 turns signalling on;
- an 8-bit priority threshold;
- an acknowledge word, which has a side effect when read;
- a completion word, which is write-only.

Reading the acknowledge slot does one of two things:

- If a candidate qualifies, the read claims it. The port sends a one-cycle activate pulse with the tag to the distributor.
- Otherwise the read returns the idle number 1023.

Writing the claimed tag to the completion slot releases the interrupt. The port then sends a one-cycle deactivate pulse. Only one interrupt can be claimed at a time.

The register bus is a plain request/response pair with no back-pressure. A request is held for exactly one cycle. A read answer appears on `rd_data_o` one cycle after its request, marked by `rd_valid_o`. Write requests produce no response. The candidate interface and the pulse outputs have no handshake. The distributor presents a candidate whenever it has one, and it must act on each pulse in the cycle the pulse is high.

Top module: `cpu_irq_port`

## Requirements
- R1: After reset the control word reads 0, the threshold reads 0, nothing is claimed, `irq_o` is low, and an acknowledge read returns 1023.
- R2: Bit 0 of the control word (slot 0) enables signalling; while it is 0, `irq_o` stays low and acknowledge reads return 1023.
- R3: A candidate is signalled only when its priority value is strictly less than the threshold (slot 1); equal or greater values are not signalled.
- R4: An acknowledge read (slot 2) of a qualifying candidate returns the interrupt number in bits 9:0. Bits 12:10 hold the requester field when the number is below 16; they are 0 otherwise. All higher bits are 0.
- R5: When no candidate qualifies, an acknowledge read returns 1023 and produces no activate pulse.
- R6: A claiming read raises `act_valid_o` for exactly one cycle, with the same number and requester field that the read returned. In that same cycle `irq_o` is low.
- R7: A completion write (slot 3) whose bits 12:0 equal the claimed tag raises `deact_valid_o` for one cycle with that tag. It also releases the claim, so the next candidate can be signalled.
- R8: A completion write with a different tag, with number 1023, or with nothing claimed is ignored. It gives no deactivate pulse and the claim is kept.
- R9: Control reads back only bit 0 and the threshold reads back only bits 7:0, with the other bits 0; slot 3 reads 0.
- R10: While one interrupt is claimed, further acknowledge reads return 1023 and `irq_o` stays low, even with a qualifying candidate present.
- R11: Candidate numbers 1021 to 1023 are never signalled or claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req_i | input | 1 | Register bus request, one cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Word slot: 0 control, 1 threshold, 2 acknowledge, 3 completion |
| bus_wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read answer valid |
| rd_data_o | output | 32 | Read answer |
| cand_valid_i | input | 1 | Distributor offers a candidate |
| cand_id_i | input | 10 | Candidate interrupt number |
| cand_src_i | input | 3 | Requester field of a software interrupt |
| cand_prio_i | input | 8 | Candidate priority, lower is more urgent |
| irq_o | output | 1 | Interrupt request to the processor |
| act_valid_o | output | 1 | Activate pulse to the distributor |
| act_id_o | output | 10 | Number being activated |
| act_src_o | output | 3 | Requester field being activated |
| deact_valid_o | output | 1 | Deactivate pulse to the distributor |
| deact_id_o | output | 10 | Number being deactivated |
| deact_src_o | output | 3 | Requester field being deactivated |

## Verification
`irq_o` is combinational from the registers and the candidate inputs. It is due just after the clock edge that accepts a control or threshold write or a claiming read. Read answers and activate pulses are registered at the edge that accepts the read, and deactivate pulses at the edge that accepts the completion write. Every bus task therefore drives its request on a falling edge, waits for the next rising edge, and samples 1 ns later. That window is when `irq_o`, `rd_data_o` and both pulse outputs all hold the effect of the request. The bench also samples one cycle later to confirm that each pulse has already ended.

// File: rtl/cip_pkg.sv
package cip_pkg;
  typedef enum logic [1:0] {
    SLOT_CTRL  = 2'd0,
    SLOT_THRES = 2'd1,
    SLOT_ACK   = 2'd2,
    SLOT_DONE  = 2'd3
  } slot_e;
endpackage

// File: rtl/cip_regs.sv
module cip_regs #(
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  cip_pkg::slot_e    slot,
  input  logic [PRIO_W-1:0] wdata,
  output logic              en,
  output logic [PRIO_W-1:0] thres
);
  import cip_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en    <= 1'b0;
      thres <= '0;
    end else if (wr_en) begin
      if (slot == SLOT_CTRL)  en    <= wdata[0];
      if (slot == SLOT_THRES) thres <= wdata;
    end
  end

  // R9: threshold changes only through its own slot
  p_thres_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && slot == SLOT_THRES) |=> $stable(thres));
  // R2: enable changes only through the control slot
  p_en_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && slot == SLOT_CTRL) |=> $stable(en));
endmodule

// File: rtl/cip_gate.sv
module cip_gate #(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8
) (
  input  logic              en,
  input  logic [PRIO_W-1:0] thres,
  input  logic              busy,
  input  logic              cand_valid,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [PRIO_W-1:0] cand_prio,
  output logic              qualify
);
  // the top three numbers are reserved and never real sources
  localparam logic [ID_W-1:0] FIRST_RSVD = ID_W'((1 << ID_W) - 3);

  logic id_ok;
  logic prio_ok;

  always_comb begin
    id_ok   = cand_id < FIRST_RSVD;
    prio_ok = cand_prio < thres;
    qualify = en && cand_valid && !busy && id_ok && prio_ok;
  end
endmodule

// File: rtl/cip_track.sv
module cip_track #(
  parameter int ID_W    = 10,
  parameter int SRC_W   = 3,
  parameter int SGI_NUM = 16,
  localparam int TAG_W  = ID_W + SRC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_rd,
  input  logic             done_wr,
  input  logic [TAG_W-1:0] done_tag,
  input  logic             qualify,
  input  logic [ID_W-1:0]  cand_id,
  input  logic [SRC_W-1:0] cand_src,
  output logic             busy,
  output logic [TAG_W-1:0] ack_tag,
  output logic             act_pulse,
  output logic [TAG_W-1:0] act_tag,
  output logic             deact_pulse,
  output logic [TAG_W-1:0] deact_tag
);
  localparam logic [ID_W-1:0] IDLE_ID = '1;

  logic [SRC_W-1:0] src_kept;
  logic [TAG_W-1:0] held;
  logic             done_hit;

  generate
    if (SGI_NUM > 0) begin : g_sgi
      always_comb src_kept = (cand_id < ID_W'(SGI_NUM)) ? cand_src : '0;
    end else begin : g_no_sgi
      always_comb src_kept = '0;
    end
  endgenerate

  always_comb begin
    ack_tag  = qualify ? {src_kept, cand_id} : {{SRC_W{1'b0}}, IDLE_ID};
    done_hit = done_wr && busy && (done_tag == held) &&
               (done_tag[ID_W-1:0] != IDLE_ID);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      held        <= '0;
      act_pulse   <= 1'b0;
      act_tag     <= '0;
      deact_pulse <= 1'b0;
      deact_tag   <= '0;
    end else begin
      act_pulse   <= 1'b0;
      deact_pulse <= 1'b0;
      if (ack_rd && qualify) begin
        busy      <= 1'b1;
        held      <= ack_tag;
        act_pulse <= 1'b1;
        act_tag   <= ack_tag;
      end else if (done_hit) begin
        busy        <= 1'b0;
        deact_pulse <= 1'b1;
        deact_tag   <= held;
      end
    end
  end

  // R6: activate is a single-cycle pulse and leaves a claim behind
  p_act_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act_pulse |=> !act_pulse);
  p_act_claims_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act_pulse |-> busy);
  // R7: deactivate releases the claim and names what was activated
  p_deact_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
    deact_pulse |-> !busy);
  // R8: a claim is dropped only together with a deactivate pulse
  p_drop_only_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> deact_pulse);
  // R10: no second claim while one is held
  p_single_claim_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !deact_pulse |=> !act_pulse);
endmodule

// File: rtl/cpu_irq_port.sv
module cpu_irq_port #(
  parameter int ID_W    = 10,
  parameter int SRC_W   = 3,
  parameter int PRIO_W  = 8,
  parameter int SGI_NUM = 16,
  parameter int DATA_W  = 32,
  localparam int TAG_W  = ID_W + SRC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req_i,
  input  logic              bus_wr_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              cand_valid_i,
  input  logic [ID_W-1:0]   cand_id_i,
  input  logic [SRC_W-1:0]  cand_src_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  output logic              irq_o,
  output logic              act_valid_o,
  output logic [ID_W-1:0]   act_id_o,
  output logic [SRC_W-1:0]  act_src_o,
  output logic              deact_valid_o,
  output logic [ID_W-1:0]   deact_id_o,
  output logic [SRC_W-1:0]  deact_src_o
);
  import cip_pkg::*;

  slot_e             slot;
  logic              wr_en;
  logic              rd_en;
  logic              en;
  logic [PRIO_W-1:0] thres;
  logic              busy;
  logic              qualify;
  logic [TAG_W-1:0]  ack_tag;
  logic [TAG_W-1:0]  act_tag;
  logic [TAG_W-1:0]  deact_tag;
  logic              unused_wdata_hi;

  always_comb begin
    slot            = slot_e'(bus_addr_i);
    wr_en           = bus_req_i && bus_wr_i;
    rd_en           = bus_req_i && !bus_wr_i;
    unused_wdata_hi = ^bus_wdata_i[DATA_W-1:TAG_W];
  end

  cip_regs #(.PRIO_W(PRIO_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .slot  (slot),
    .wdata (bus_wdata_i[PRIO_W-1:0]),
    .en    (en),
    .thres (thres)
  );

  cip_gate #(.ID_W(ID_W), .PRIO_W(PRIO_W)) u_gate (
    .en         (en),
    .thres      (thres),
    .busy       (busy),
    .cand_valid (cand_valid_i),
    .cand_id    (cand_id_i),
    .cand_prio  (cand_prio_i),
    .qualify    (qualify)
  );

  cip_track #(.ID_W(ID_W), .SRC_W(SRC_W), .SGI_NUM(SGI_NUM)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_rd      (rd_en && slot == SLOT_ACK),
    .done_wr     (wr_en && slot == SLOT_DONE),
    .done_tag    (bus_wdata_i[TAG_W-1:0]),
    .qualify     (qualify),
    .cand_id     (cand_id_i),
    .cand_src    (cand_src_i),
    .busy        (busy),
    .ack_tag     (ack_tag),
    .act_pulse   (act_valid_o),
    .act_tag     (act_tag),
    .deact_pulse (deact_valid_o),
    .deact_tag   (deact_tag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en;
      if (rd_en) begin
        case (slot)
          SLOT_CTRL:  rd_data_o <= DATA_W'(en);
          SLOT_THRES: rd_data_o <= DATA_W'(thres);
          SLOT_ACK:   rd_data_o <= DATA_W'(ack_tag);
          default:    rd_data_o <= '0;
        endcase
      end
    end
  end

  always_comb begin
    irq_o       = qualify;
    act_id_o    = act_tag[ID_W-1:0];
    act_src_o   = act_tag[TAG_W-1:ID_W];
    deact_id_o  = deact_tag[ID_W-1:0];
    deact_src_o = deact_tag[TAG_W-1:ID_W];
  end

  // R2: no request without the enable bit
  p_irq_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> en);
  // R3: a request always carries a priority below the threshold
  p_irq_below_thres_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> cand_valid_i && cand_prio_i < thres);
  // R5: an idle answer never comes with an activate pulse
  p_idle_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && rd_data_o[ID_W-1:0] == '1 |-> !act_valid_o);
  // R6: request line is low while activating
  p_irq_low_on_act_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid_o |-> !irq_o);
  // R11: reserved numbers are never activated
  p_no_rsvd_act_r11: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid_o |-> act_id_o < ID_W'((1 << ID_W) - 3));
endmodule

// File: tb/test_cpu_irq_port.sv
`timescale 1ns/1ps
module test_cpu_irq_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req_i = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic [1:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic        rd_valid_o;
  logic [31:0] rd_data_o;
  logic        cand_valid_i = 1'b0;
  logic [9:0]  cand_id_i = '0;
  logic [2:0]  cand_src_i = '0;
  logic [7:0]  cand_prio_i = '0;
  logic        irq_o;
  logic        act_valid_o;
  logic [9:0]  act_id_o;
  logic [2:0]  act_src_o;
  logic        deact_valid_o;
  logic [9:0]  deact_id_o;
  logic [2:0]  deact_src_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [31:0] got_rd;
  logic        got_rv;
  logic        got_act;
  logic        got_irq;
  logic        got_deact;

  cpu_irq_port i_cpu_irq_port (.*);

  always #10 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(posedge clk); #1;
    got_deact = deact_valid_o;
    got_irq   = irq_o;
    @(negedge clk);
    bus_req_i = 1'b0; bus_wr_i = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a);
    @(negedge clk);
    bus_req_i = 1'b1; bus_wr_i = 1'b0; bus_addr_i = a;
    @(posedge clk); #1;
    got_rd  = rd_data_o;
    got_rv  = rd_valid_o;
    got_act = act_valid_o;
    got_irq = irq_o;
    @(negedge clk);
    bus_req_i = 1'b0;
  endtask

  task automatic offer(input logic v, input logic [9:0] id,
                       input logic [2:0] src, input logic [7:0] prio);
    @(negedge clk);
    cand_valid_i = v; cand_id_i = id; cand_src_i = src; cand_prio_i = prio;
  endtask

  task automatic t_reset();
    offer(1'b1, 10'd50, 3'd0, 8'h00);
    #1 check("R1", "irq after reset", 32'(irq_o), 32'd0);
    bus_read(2'd0); check("R1", "control", got_rd, 32'd0);
    check("R1", "read valid", 32'(got_rv), 32'd1);
    bus_read(2'd1); check("R1", "threshold", got_rd, 32'd0);
    bus_read(2'd2); check("R1", "ack idle", got_rd, 32'd1023);
    check("R5", "no act on idle", 32'(got_act), 32'd0);
  endtask

  task automatic t_regs();
    bus_write(2'd0, 32'hFFFF_FFFF);
    bus_read(2'd0); check("R9", "control readback", got_rd, 32'd1);
    bus_write(2'd1, 32'h0000_1234);
    bus_read(2'd1); check("R9", "threshold readback", got_rd, 32'h34);
    bus_read(2'd3); check("R9", "completion slot reads", got_rd, 32'd0);
    bus_write(2'd0, 32'd0);
  endtask

  task automatic t_enable();
    bus_write(2'd1, 32'hF0);
    offer(1'b1, 10'd40, 3'd0, 8'h80);
    #1 check("R2", "irq while disabled", 32'(irq_o), 32'd0);
    bus_read(2'd2); check("R2", "ack while disabled", got_rd, 32'd1023);
    bus_write(2'd0, 32'd1); check("R2", "irq after enable", 32'(got_irq), 32'd1);
    bus_write(2'd0, 32'd0); check("R2", "irq after disable", 32'(got_irq), 32'd0);
    bus_write(2'd0, 32'd1);
  endtask

  task automatic t_threshold();
    bus_write(2'd1, 32'h80);
    offer(1'b1, 10'd40, 3'd0, 8'h80);
    #1 check("R3", "prio equal to threshold", 32'(irq_o), 32'd0);
    offer(1'b1, 10'd40, 3'd0, 8'h7F);
    #1 check("R3", "prio just below", 32'(irq_o), 32'd1);
    offer(1'b1, 10'd40, 3'd0, 8'hC0);
    #1 check("R3", "prio above", 32'(irq_o), 32'd0);
    offer(1'b1, 10'd1022, 3'd0, 8'h00);
    #1 check("R11", "reserved number irq", 32'(irq_o), 32'd0);
    bus_read(2'd2); check("R11", "reserved number ack", got_rd, 32'd1023);
    check("R11", "reserved no act", 32'(got_act), 32'd0);
    bus_write(2'd1, 32'hF0);
  endtask

  task automatic t_claim_shared();
    offer(1'b1, 10'd40, 3'd5, 8'h10);
    bus_read(2'd2);
    check("R4", "ack shared number", got_rd, 32'd40);
    check("R6", "act pulse", 32'(got_act), 32'd1);
    check("R6", "act id", 32'(act_id_o), 32'd40);
    check("R6", "act src", 32'(act_src_o), 32'd0);
    check("R6", "irq low with act", 32'(got_irq), 32'd0);
    @(posedge clk); #1 check("R6", "act ends", 32'(act_valid_o), 32'd0);
    bus_read(2'd2);
    check("R10", "second ack idle", got_rd, 32'd1023);
    check("R10", "no second act", 32'(got_act), 32'd0);
    check("R10", "irq held low", 32'(got_irq), 32'd0);
    bus_write(2'd3, 32'd41);
    check("R8", "wrong tag no deact", 32'(got_deact), 32'd0);
    bus_write(2'd3, 32'd1023);
    check("R8", "idle tag no deact", 32'(got_deact), 32'd0);
    bus_read(2'd2); check("R8", "claim kept", got_rd, 32'd1023);
    bus_write(2'd3, 32'd40);
    check("R7", "deact pulse", 32'(got_deact), 32'd1);
    check("R7", "deact id", 32'(deact_id_o), 32'd40);
    check("R7", "irq again", 32'(got_irq), 32'd1);
    @(posedge clk); #1 check("R7", "deact ends", 32'(deact_valid_o), 32'd0);
    bus_write(2'd3, 32'd40);
    check("R8", "done with nothing claimed", 32'(got_deact), 32'd0);
  endtask

  task automatic t_claim_soft();
    offer(1'b1, 10'd3, 3'd6, 8'h20);
    bus_read(2'd2);
    check("R4", "ack software tag", got_rd, (32'd6 << 10) | 32'd3);
    check("R6", "act software src", 32'(act_src_o), 32'd6);
    bus_write(2'd3, 32'd3);
    check("R8", "missing src no deact", 32'(got_deact), 32'd0);
    bus_write(2'd3, (32'd6 << 10) | 32'd3);
    check("R7", "software deact", 32'(got_deact), 32'd1);
    check("R7", "software deact src", 32'(deact_src_o), 32'd6);
    offer(1'b0, 10'd0, 3'd0, 8'h00);
    bus_read(2'd2); check("R5", "no candidate idle", got_rd, 32'd1023);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_regs();
    t_enable();
    t_threshold();
    t_claim_shared();
    t_claim_soft();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule